// File: doc/BRIEF.md
# Clock-Domain-Crossing Configuration Write Bridge

This block lets a bus running on the system clock write a small bank of configuration registers that are clocked by a separate, unrelated peripheral oscillator. A write is accepted in the bus domain, and its address and data are held there. A request toggle then travels through a two-flop synchronizer into the peripheral domain. That domain commits the write to its register and returns an acknowledge toggle through a second two-flop synchronizer. The peripheral-side registers drive the block that sits behind the bridge.

Software learns that a write has finished from a write-complete status bit. The bit is cleared when a write is accepted and set once the acknowledge is back. Reads never wait: they return a bus-domain shadow copy, which is refreshed when the acknowledge arrives. A write that arrives while another is still in flight is discarded, and a sticky error bit is raised. Address 0 is the control register. Its two low bits read as status: bit 0 is write-complete and bit 1 is the sticky error. Its upper bits are ordinary configuration that crosses like any other register.

The source side is a two-state machine. In SRC_IDLE, an accepted write takes the transition "launch" to SRC_WAIT. In SRC_WAIT, a matching acknowledge takes the transition "retire" back to SRC_IDLE. The destination side is also a two-state machine. In DST_IDLE, a new request takes the transition "detect" to DST_COMMIT. In DST_COMMIT, the transition "answer" writes the register, toggles the acknowledge and returns to DST_IDLE.

Top module: `cdc_wr_bridge`

## Requirements
- R1: After reset, the write-complete bit (address 0, bit 0) reads 1 and the error bit (address 0, bit 1) reads 0. Every register reads its reset value, with bits 1:0 of address 0 stored as 0, and the peripheral-side outputs hold the same reset values.
- R2: A write accepted while write-complete is 1 clears write-complete, and a read issued in the very next cycle shows bit 0 = 0.
- R3: Each accepted write reaches the peripheral-side register exactly once and with the written data. The peripheral-side registers change only in the cycle after a commit.
- R4: Write-complete returns to 1 only after the peripheral-side commit has happened. From then on, a read of the written address returns the new data.
- R5: Reads are never stalled. Back-to-back reads in consecutive cycles while a write is pending return the pre-write value, because the shadow copy changes only when the write retires.
- R6: A write issued while write-complete is 0 is dropped: neither the peripheral-side register nor the read value changes. It sets the error bit, which stays 1 until reset.
- R7: The held address and data stay stable in the bus domain for as long as a write is pending.
- R8: A write to address 0 stores bits 31:2 and crosses them like any other register. Its bits 1:0 are ignored: they are stored as 0, and on a read they always show the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | System (bus) clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe; data appears the cycle after |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data from the shadow copy and status |
| per_clk | input | 1 | Independent peripheral clock |
| per_rst_n | input | 1 | Active-low reset, peripheral domain |
| per_cfg_q | output | DW*2**AW | Peripheral-side registers, register i at bits [i*DW +: DW] |

## Verification
The bench first tries an isolated write followed by polling, which shows that the handshake completes and that the data arrives on both sides. Reads placed back-to-back during a pending write tell a shadow that updates at retirement apart from one that updates at acceptance. A second write one cycle after the first separates correct dropping from overwriting, and checks that the error bit stays set. A write of all ones to the control register, followed by a sweep that writes a distinct pattern to every address, tells proper masking of the status bits apart from address aliasing.

// File: rtl/cdc_wr_bridge_pkg.sv
package cdc_wr_bridge_pkg;
    typedef enum logic {
        SRC_IDLE,
        SRC_WAIT
    } src_state_t;

    typedef enum logic {
        DST_IDLE,
        DST_COMMIT
    } dst_state_t;

    localparam int STAT_BITS = 2;
endpackage

// File: rtl/cdc_sync2.sv
module cdc_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cdc_wr_src.sv
module cdc_wr_src
    import cdc_wr_bridge_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          ack_sync,
    output logic          req_tgl,
    output logic [AW-1:0] hold_addr,
    output logic [DW-1:0] hold_data,
    output logic          wr_done,
    output logic          err_flag,
    output logic          retire
);
    src_state_t state, state_nx;

    // Transition "retire": acknowledge toggle has caught up with the request.
    assign retire = (state == SRC_WAIT) && (ack_sync == req_tgl);

    always_comb begin
        state_nx = state;
        unique case (state)
            SRC_IDLE: if (wr_en)  state_nx = SRC_WAIT;   // launch
            SRC_WAIT: if (retire) state_nx = SRC_IDLE;   // retire
            default:              state_nx = SRC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SRC_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_tgl   <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
            wr_done   <= 1'b1;
            err_flag  <= 1'b0;
        end else begin
            unique case (state)
                SRC_IDLE: begin
                    if (wr_en) begin
                        hold_addr <= addr;
                        hold_data <= wdata;
                        req_tgl   <= ~req_tgl;
                        wr_done   <= 1'b0;
                    end
                end
                SRC_WAIT: begin
                    if (wr_en)  err_flag <= 1'b1;
                    if (retire) wr_done  <= 1'b1;
                end
                default: wr_done <= 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/cdc_wr_dst.sv
module cdc_wr_dst
    import cdc_wr_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_sync,
    output logic ack_tgl,
    output logic wr_pulse
);
    dst_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            DST_IDLE:   if (req_sync != ack_tgl) state_nx = DST_COMMIT;  // detect
            DST_COMMIT:                          state_nx = DST_IDLE;    // answer
            default:                             state_nx = DST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DST_IDLE;
        else        state <= state_nx;
    end

    assign wr_pulse = (state == DST_COMMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ack_tgl <= 1'b0;
        else if (wr_pulse) ack_tgl <= ~ack_tgl;
    end
endmodule

// File: rtl/cdc_wr_bridge.sv
module cdc_wr_bridge
    import cdc_wr_bridge_pkg::*;
#(
    parameter int          AW      = 2,
    parameter int          DW      = 32,
    parameter logic [31:0] RST_VAL = 32'h0000_A5F0
) (
    input  logic                    bus_clk,
    input  logic                    bus_rst_n,
    input  logic                    bus_wr_en,
    input  logic                    bus_rd_en,
    input  logic [AW-1:0]           bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    input  logic                    per_clk,
    input  logic                    per_rst_n,
    output logic [DW*(1<<AW)-1:0]   per_cfg_q
);
    localparam int NREGS = 1 << AW;
    localparam logic [DW-1:0] RST_W = DW'(RST_VAL);
    localparam logic [DW-1:0] STAT_MASK = {{(DW-STAT_BITS){1'b1}}, {STAT_BITS{1'b0}}};

    logic [DW-1:0]        wdata_m;
    logic                 req_tgl, req_sync, ack_tgl, ack_sync;
    logic [AW-1:0]        hold_addr;
    logic [DW-1:0]        hold_data;
    logic                 wr_done, err_flag, retire, per_wr_pulse;
    logic [DW-1:0]        shadow [NREGS];
    logic [DW*NREGS-1:0]  shadow_flat;

    // Status bits of the control register are never stored.
    assign wdata_m = (bus_addr == '0) ? (bus_wdata & STAT_MASK) : bus_wdata;

    cdc_wr_src #(.AW(AW), .DW(DW)) u_src (
        .clk      (bus_clk),
        .rst_n    (bus_rst_n),
        .wr_en    (bus_wr_en),
        .addr     (bus_addr),
        .wdata    (wdata_m),
        .ack_sync (ack_sync),
        .req_tgl  (req_tgl),
        .hold_addr(hold_addr),
        .hold_data(hold_data),
        .wr_done  (wr_done),
        .err_flag (err_flag),
        .retire   (retire)
    );

    cdc_sync2 #(.W(1)) u_req_sync (
        .clk(per_clk), .rst_n(per_rst_n), .d(req_tgl), .q(req_sync)
    );

    cdc_sync2 #(.W(1)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_sync)
    );

    cdc_wr_dst u_dst (
        .clk     (per_clk),
        .rst_n   (per_rst_n),
        .req_sync(req_sync),
        .ack_tgl (ack_tgl),
        .wr_pulse(per_wr_pulse)
    );

    // hold_addr/hold_data are quasi-static while the request is in flight.
    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        localparam logic [DW-1:0] RV = (i == 0) ? (RST_W & STAT_MASK) : RST_W;

        always_ff @(posedge per_clk or negedge per_rst_n) begin
            if (!per_rst_n)
                per_cfg_q[i*DW +: DW] <= RV;
            else if (per_wr_pulse && hold_addr == AW'(i))
                per_cfg_q[i*DW +: DW] <= hold_data;
        end

        always_ff @(posedge bus_clk or negedge bus_rst_n) begin
            if (!bus_rst_n)
                shadow[i] <= RV;
            else if (retire && hold_addr == AW'(i))
                shadow[i] <= hold_data;
        end

        assign shadow_flat[i*DW +: DW] = shadow[i];
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n)
            bus_rdata <= '0;
        else if (bus_rd_en) begin
            if (bus_addr == '0)
                bus_rdata <= {shadow[0][DW-1:STAT_BITS], err_flag, wr_done};
            else
                bus_rdata <= shadow[bus_addr];
        end
    end
endmodule

// File: rtl/cdc_wr_bridge_chk.sv
module cdc_wr_bridge_chk #(
    parameter int AW = 2,
    parameter int DW = 32
) (
    input logic                   bus_clk,
    input logic                   bus_rst_n,
    input logic                   bus_wr_en,
    input logic                   wr_done,
    input logic                   err_flag,
    input logic [AW-1:0]          hold_addr,
    input logic [DW-1:0]          hold_data,
    input logic [DW*(1<<AW)-1:0]  shadow_flat,
    input logic                   per_clk,
    input logic                   per_rst_n,
    input logic                   per_wr_pulse,
    input logic [DW*(1<<AW)-1:0]  per_cfg_q
);
    a_r2_done_clears: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (bus_wr_en && wr_done) |=> !wr_done);

    a_r6_drop_flags: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (bus_wr_en && !wr_done) |=> err_flag);

    a_r6_err_sticky: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        err_flag |=> err_flag);

    a_r7_hold_stable: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (!wr_done && $past(!wr_done)) |-> ($stable(hold_addr) && $stable(hold_data)));

    a_r5_shadow_on_retire: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !$rose(wr_done) |-> $stable(shadow_flat));

    a_r3_cfg_only_on_commit: assert property (@(posedge per_clk) disable iff (!per_rst_n)
        !per_wr_pulse |=> $stable(per_cfg_q));

    a_r3_single_commit: assert property (@(posedge per_clk) disable iff (!per_rst_n)
        per_wr_pulse |=> !per_wr_pulse);
endmodule

bind cdc_wr_bridge cdc_wr_bridge_chk #(.AW(AW), .DW(DW)) u_chk (
    .bus_clk     (bus_clk),
    .bus_rst_n   (bus_rst_n),
    .bus_wr_en   (bus_wr_en),
    .wr_done     (wr_done),
    .err_flag    (err_flag),
    .hold_addr   (hold_addr),
    .hold_data   (hold_data),
    .shadow_flat (shadow_flat),
    .per_clk     (per_clk),
    .per_rst_n   (per_rst_n),
    .per_wr_pulse(per_wr_pulse),
    .per_cfg_q   (per_cfg_q)
);

// File: tb/sim_cdc_wr_bridge.sv
module sim_cdc_wr_bridge;
    localparam int AW = 2;
    localparam int DW = 32;
    localparam int NR = 1 << AW;
    localparam time BUS_PERIOD = 10ns;
    localparam time PER_PERIOD = 26ns;
    localparam logic [31:0] RSTV = 32'h0000_A5F0;

    logic bus_clk = 0, per_clk = 0, bus_rst_n = 0, per_rst_n = 0;
    logic bus_wr_en = 0, bus_rd_en = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [DW*NR-1:0] per_cfg_q;

    always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
    always #(PER_PERIOD/2) per_clk = ~per_clk;

    cdc_wr_bridge #(.AW(AW), .DW(DW), .RST_VAL(RSTV)) u0 (.*);

    int checks = 0, errors = 0;
    bit polling = 0, finished = 0;
    logic [DW-1:0] model [NR];
    bit err_exp = 0;
    logic [DW-1:0] exp_q[$];
    string tag_q[$];

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] stat_word(input bit done);
        return {model[0][DW-1:2], err_exp, done};
    endfunction

    // Monitor: compares scoreboarded reads one cycle after the strobe.
    always @(posedge bus_clk) begin
        if (bus_rd_en && !polling && bus_rst_n) begin
            #1;
            if (exp_q.size() == 0) chk(bus_rdata, 'x, "scoreboard underflow");
            else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic rd_exp(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge bus_clk); bus_rd_en = 1; bus_addr = a;
        @(negedge bus_clk); bus_rd_en = 0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge bus_clk); bus_wr_en = 1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk); bus_wr_en = 0;
    endtask

    task automatic poll_done(input string tag);
        bit seen = 0;
        polling = 1;
        for (int n = 0; n < 80 && !seen; n++) begin
            @(negedge bus_clk); bus_rd_en = 1; bus_addr = '0;
            @(negedge bus_clk); bus_rd_en = 0;
            seen = bus_rdata[0];
        end
        polling = 0;
        chk({31'b0, seen}, 32'd1, tag);
    endtask

    task automatic wr_full(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] dm = (a == 0) ? (d & 32'hFFFF_FFFC) : d;
        wr(a, d);
        poll_done("R4 write-complete returns");
        model[a] = dm;
        chk(per_cfg_q[a*DW +: DW], dm, "R3 peripheral register value");
        if (a == 0) rd_exp(a, stat_word(1), "R4 readback");
        else        rd_exp(a, dm, "R4 readback");
    endtask

    initial begin
        for (int i = 0; i < NR; i++) model[i] = (i == 0) ? (RSTV & 32'hFFFF_FFFC) : RSTV;
        repeat (3) @(negedge bus_clk);
        bus_rst_n = 1; per_rst_n = 1;
        repeat (2) @(negedge bus_clk);

        // R1: reset state
        rd_exp(0, stat_word(1), "R1 reset status");
        for (int i = 1; i < NR; i++) rd_exp(AW'(i), model[i], "R1 reset value");
        for (int i = 0; i < NR; i++) chk(per_cfg_q[i*DW +: DW], model[i], "R1 peripheral reset");

        // R2, R5: accept a write, then back-to-back reads while pending
        wr(2, 32'hDEAD_BEEF);
        exp_q.push_back(stat_word(0)); tag_q.push_back("R2 done cleared");
        exp_q.push_back(model[2]);      tag_q.push_back("R5 old value read 1");
        exp_q.push_back(model[2]);      tag_q.push_back("R5 old value read 2");
        @(negedge bus_clk); bus_rd_en = 1; bus_addr = 0;
        @(negedge bus_clk); bus_addr = 2;
        @(negedge bus_clk);
        @(negedge bus_clk); bus_rd_en = 0;
        poll_done("R4 write-complete returns");
        model[2] = 32'hDEAD_BEEF;
        chk(per_cfg_q[2*DW +: DW], model[2], "R3 peripheral register value");
        rd_exp(2, model[2], "R4 readback");

        // R6: second write while pending is dropped
        wr(1, 32'h1234_5678);
        wr(3, 32'hCAFE_0003);
        err_exp = 1;
        poll_done("R6 first write completes");
        model[1] = 32'h1234_5678;
        repeat (20) @(negedge bus_clk);
        chk(per_cfg_q[3*DW +: DW], model[3], "R6 dropped write, peripheral unchanged");
        rd_exp(3, model[3], "R6 dropped write, read unchanged");
        rd_exp(1, model[1], "R6 accepted write kept");
        rd_exp(0, stat_word(1), "R6 error bit set");

        // R8: control register low bits ignored
        wr_full(0, 32'hFFFF_FFFF);
        chk(per_cfg_q[DW-1:0], 32'hFFFF_FFFC, "R8 control low bits stored as zero");

        // Sweep of distinct patterns; R6 error stays set
        for (int i = 0; i < NR; i++) wr_full(AW'(i), 32'h0F0F_0000 ^ (32'h1111_1111 * (i + 1)));
        for (int i = 1; i < NR; i++) rd_exp(AW'(i), model[i], "R4 sweep readback");
        rd_exp(0, stat_word(1), "R6 error sticky after sweep");

        repeat (4) @(negedge bus_clk);
        if (exp_q.size() != 0) chk(32'(exp_q.size()), 0, "scoreboard leftover");
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(BUS_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule